// File: doc/BRIEF.md
# Floating-Point Condition Code Generator

This block turns the result of a floating-point comparison, or the class of an extended-precision operand, into the four condition bits of a 16-bit floating-point status word. For a comparison it can instead produce the zero, parity and carry flags of the integer flags register. The comparison and the operand come from neighbouring logic. This block only maps them onto bits.

Each request is a single-cycle strobe. The strobe carries an operation code, a 2-bit comparison outcome, the current status word, an 80-bit operand and an empty marker for that operand. On the strobe edge the block registers the new status word, or the new flag triple. One cycle after the strobe it raises a done pulse.

The condition bits sit at scattered positions in the status word: C0 at bit 8, C1 at bit 9, C2 at bit 10 and C3 at bit 14. Every bit that the selected operation does not own is copied from the incoming status word unchanged.

Top module: `cc_gen`

## Requirements
- R1: During and right after reset, `status_o` is 16'h0000, `zf_o`, `pf_o` and `cf_o` are 0, and `done_o` is 0.
- R2: Operation code 2'b00 is a status-word compare. It ORs in 16'h0100 for outcome 2'b00 (less), 16'h4000 for 2'b01 (equal), 16'h0000 for 2'b10 (greater) and 16'h4500 for 2'b11 (unordered).
- R3: A status-word compare first clears bits 14, 10 and 8 of `status_i`. Every other bit, C1 included, reaches `status_o` unchanged.
- R4: Operation code 2'b01 is a flags compare. It sets the flags {zf,pf,cf} to 3'b001 for less, 3'b100 for equal, 3'b000 for greater and 3'b111 for unordered, and registers `status_i` unchanged. The flags keep their value through every other operation.
- R5: Operation code 2'b10 is an examine. It clears bits 14, 10, 9 and 8, copies operand bit 79 (the sign) into bit 9, and passes the remaining bits of `status_i` unchanged.
- R6: In an examine of a non-empty operand, exponent field bits 78:64 equal to 15'h7FFF with mantissa bits 63:0 exactly 64'h8000_0000_0000_0000 is infinity and sets bits 10 and 8. Any other mantissa with that exponent is a NaN and sets bit 8 only.
- R7: In an examine of a non-empty operand, a zero exponent with a zero mantissa sets bit 14. A zero exponent with a nonzero mantissa sets bits 14 and 10.
- R8: In an examine, every other non-empty operand, including one whose integer bit 63 is clear, sets bit 10 only.
- R9: In an examine with `empty_i` high, bits 14 and 8 are set whatever the exponent and mantissa hold. The sign is still copied into bit 9.
- R10: `done_o` is high for exactly the cycle after each cycle in which `valid_i` was high. Back-to-back strobes give back-to-back done cycles, each with its own result.
- R11: While `valid_i` is low, `status_o` and the flags hold, whatever happens on the other inputs.
- R12: Operation code 2'b11 registers `status_i` unchanged, leaves the flags alone and still produces a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation: 00 status compare, 01 flags compare, 10 examine, 11 pass |
| outcome_i | input | 2 | Compare outcome: 00 less, 01 equal, 10 greater, 11 unordered |
| status_i | input | 16 | Current status word |
| operand_i | input | 80 | Extended operand: sign 79, exponent 78:64, mantissa 63:0 |
| empty_i | input | 1 | Operand register is empty |
| status_o | output | 16 | Registered status word |
| zf_o | output | 1 | Registered zero flag |
| pf_o | output | 1 | Registered parity flag |
| cf_o | output | 1 | Registered carry flag |
| done_o | output | 1 | Pulse one cycle after a strobe |

## Verification
Two things can fall in the same cycle: the done pulse of one request and the strobe of the next. The bench provokes this by holding `valid_i` high over several edges with a different operation on each edge: a flags compare, then an examine, then a status compare. For each of these cycles it checks that `done_o` stays high, that `status_o` carries that cycle's own result, and that the flags are still the value set by the flags compare. The empty marker and a special operand class can also meet in one examine. An empty register holding an infinity encoding must read as empty, not as infinity.

// File: rtl/cc_pkg.sv
package cc_pkg;

  localparam int SW_W   = 16;
  localparam int C0_POS = 8;
  localparam int C1_POS = 9;
  localparam int C2_POS = 10;
  localparam int C3_POS = 14;

  localparam logic [SW_W-1:0] ONE_W   = {{(SW_W-1){1'b0}}, 1'b1};
  localparam logic [SW_W-1:0] CMP_MASK  = (ONE_W << C3_POS) | (ONE_W << C2_POS) | (ONE_W << C0_POS);
  localparam logic [SW_W-1:0] EXAM_MASK = CMP_MASK | (ONE_W << C1_POS);

  typedef enum logic [1:0] {
    OP_SW_CMP = 2'b00,
    OP_FL_CMP = 2'b01,
    OP_EXAM   = 2'b10,
    OP_PASS   = 2'b11
  } cc_op_e;

  typedef enum logic [1:0] {
    RES_LT = 2'b00,
    RES_EQ = 2'b01,
    RES_GT = 2'b10,
    RES_UN = 2'b11
  } cc_res_e;

  typedef struct packed {
    logic zf;
    logic pf;
    logic cf;
  } cc_flags_t;

  // one-hot operand class
  typedef struct packed {
    logic empty;
    logic nan;
    logic inf;
    logic zero;
    logic denorm;
    logic normal;
  } cc_class_t;

  function automatic logic [SW_W-1:0] cc_word(input logic c3, input logic c2,
                                              input logic c1, input logic c0);
    logic [SW_W-1:0] w;
    w         = '0;
    w[C3_POS] = c3;
    w[C2_POS] = c2;
    w[C1_POS] = c1;
    w[C0_POS] = c0;
    return w;
  endfunction

  function automatic logic [SW_W-1:0] cmp_code(input cc_res_e r);
    case (r)
      RES_LT:  return cc_word(1'b0, 1'b0, 1'b0, 1'b1);
      RES_EQ:  return cc_word(1'b1, 1'b0, 1'b0, 1'b0);
      RES_GT:  return cc_word(1'b0, 1'b0, 1'b0, 1'b0);
      default: return cc_word(1'b1, 1'b1, 1'b0, 1'b1);
    endcase
  endfunction

  function automatic cc_flags_t flag_code(input cc_res_e r);
    cc_flags_t f;
    f.zf = (r == RES_EQ) || (r == RES_UN);
    f.pf = (r == RES_UN);
    f.cf = (r == RES_LT) || (r == RES_UN);
    return f;
  endfunction

  function automatic logic [SW_W-1:0] class_code(input cc_class_t c);
    logic [SW_W-1:0] w;
    w = '0;
    if (c.empty)  w = cc_word(1'b1, 1'b0, 1'b0, 1'b1);
    if (c.nan)    w = cc_word(1'b0, 1'b0, 1'b0, 1'b1);
    if (c.inf)    w = cc_word(1'b0, 1'b1, 1'b0, 1'b1);
    if (c.zero)   w = cc_word(1'b1, 1'b0, 1'b0, 1'b0);
    if (c.denorm) w = cc_word(1'b1, 1'b1, 1'b0, 0);
    if (c.normal) w = cc_word(1'b0, 1'b1, 1'b0, 1'b0);
    return w;
  endfunction

endpackage

// File: rtl/cc_classify.sv
module cc_classify
  import cc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W+MAN_W:0] opnd_i,
  input  logic                 empty_i,
  output cc_class_t            cls_o,
  output logic                 sign_o
);
  localparam int MSB = EXP_W + MAN_W;
  localparam logic [MAN_W-1:0] INF_MAN = {1'b1, {(MAN_W-1){1'b0}}};

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic exp_max, exp_min, man_zero, man_inf;

  assign sign_o   = opnd_i[MSB];
  assign exp_f    = opnd_i[MSB-1 -: EXP_W];
  assign man_f    = opnd_i[MAN_W-1:0];
  assign exp_max  = &exp_f;
  assign exp_min  = ~|exp_f;
  assign man_zero = ~|man_f;
  assign man_inf  = (man_f == INF_MAN);

  always_comb begin
    cls_o = '0;
    if (empty_i)      cls_o.empty  = 1'b1;
    else if (exp_max) begin
      if (man_inf)    cls_o.inf    = 1'b1;
      else            cls_o.nan    = 1'b1;
    end
    else if (exp_min) begin
      if (man_zero)   cls_o.zero   = 1'b1;
      else            cls_o.denorm = 1'b1;
    end
    else              cls_o.normal = 1'b1;
  end
endmodule

// File: rtl/cc_map.sv
module cc_map
  import cc_pkg::*;
(
  input  cc_op_e          op_i,
  input  cc_res_e         res_i,
  input  logic [SW_W-1:0] status_i,
  input  cc_class_t       cls_i,
  input  logic            sign_i,
  input  cc_flags_t       flags_i,
  output logic [SW_W-1:0] status_o,
  output cc_flags_t       flags_o
);
  logic [SW_W-1:0] sign_bit;
  assign sign_bit = sign_i ? (ONE_W << C1_POS) : '0;

  always_comb begin
    status_o = status_i;
    flags_o  = flags_i;
    case (op_i)
      OP_SW_CMP: status_o = (status_i & ~CMP_MASK) | cmp_code(res_i);
      OP_FL_CMP: flags_o  = flag_code(res_i);
      OP_EXAM:   status_o = (status_i & ~EXAM_MASK) | class_code(cls_i) | sign_bit;
      default:   status_o = status_i;
    endcase
  end
endmodule

// File: rtl/cc_gen.sv
module cc_gen
  import cc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [1:0]           op_i,
  input  logic [1:0]           outcome_i,
  input  logic [15:0]          status_i,
  input  logic [EXP_W+MAN_W:0] operand_i,
  input  logic                 empty_i,
  output logic [15:0]          status_o,
  output logic                 zf_o,
  output logic                 pf_o,
  output logic                 cf_o,
  output logic                 done_o
);
  localparam int OPND_W = EXP_W + MAN_W + 1;

  cc_op_e          op_e;
  cc_res_e         res_e;
  cc_class_t       cls;
  logic            sign;
  logic [SW_W-1:0] status_nxt, status_q;
  cc_flags_t       flags_nxt, flags_q;
  logic            done_q;

  assign op_e  = cc_op_e'(op_i);
  assign res_e = cc_res_e'(outcome_i);

  cc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .opnd_i (operand_i[OPND_W-1:0]),
    .empty_i(empty_i),
    .cls_o  (cls),
    .sign_o (sign)
  );

  cc_map u_map (
    .op_i    (op_e),
    .res_i   (res_e),
    .status_i(status_i),
    .cls_i   (cls),
    .sign_i  (sign),
    .flags_i (flags_q),
    .status_o(status_nxt),
    .flags_o (flags_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      flags_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= valid_i;
      if (valid_i) begin
        status_q <= status_nxt;
        flags_q  <= flags_nxt;
      end
    end
  end

  assign status_o = status_q;
  assign zf_o     = flags_q.zf;
  assign pf_o     = flags_q.pf;
  assign cf_o     = flags_q.cf;
  assign done_o   = done_q;

  // ---------------- assertions ----------------
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> done_o);
  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !done_o);
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(status_o) && $stable({zf_o, pf_o, cf_o})));
  assert_cmp_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b00) |=> ((status_o & 16'hBAFF) == ($past(status_i) & 16'hBAFF)));
  assert_flag_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b01) |=> (status_o == $past(status_i)));
  assert_flags_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i != 2'b01) |=> $stable({zf_o, pf_o, cf_o}));
  assert_exam_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b10) |=> (((status_o & 16'hB8FF) == ($past(status_i) & 16'hB8FF))
                                    && (status_o[9] == $past(operand_i[OPND_W-1]))));
  assert_class_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cls) == 1);
  assert_empty_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b10 && empty_i) |=> (status_o[14] && status_o[8] && !status_o[10]));
  assert_pass_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == 2'b11) |=> (status_o == $past(status_i)));
endmodule

// File: tb/sim_cc_gen.sv
`timescale 1ns/1ps
module sim_cc_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [1:0]  op_i, outcome_i;
  logic [15:0] status_i;
  logic [79:0] operand_i;
  logic        empty_i;
  logic [15:0] status_o;
  logic        zf_o, pf_o, cf_o, done_o;

  int nvec = 0;
  int nbad = 0;
  logic [2:0] fl_exp = 3'b000;

  always #4 clk = ~clk;

  cc_gen u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .outcome_i(outcome_i),
    .status_i(status_i), .operand_i(operand_i), .empty_i(empty_i),
    .status_o(status_o), .zf_o(zf_o), .pf_o(pf_o), .cf_o(cf_o), .done_o(done_o)
  );

  // bench-side model of the requirements
  function automatic logic [15:0] m_cmp(input logic [15:0] st, input logic [1:0] r);
    logic [15:0] v;
    case (r)
      2'd0: v = 16'h0100;
      2'd1: v = 16'h4000;
      2'd2: v = 16'h0000;
      default: v = 16'h4500;
    endcase
    return (st & 16'hBAFF) | v;
  endfunction

  function automatic logic [2:0] m_flags(input logic [1:0] r);
    case (r)
      2'd0: return 3'b001;
      2'd1: return 3'b100;
      2'd2: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [15:0] m_exam(input logic [15:0] st, input logic [79:0] x, input logic emp);
    logic [15:0] w;
    w = st & 16'hB8FF;
    if (x[79]) w = w | 16'h0200;
    if (emp) w = w | 16'h4100;
    else if (x[78:64] == 15'h7FFF) w = w | ((x[63:0] == 64'h8000_0000_0000_0000) ? 16'h0500 : 16'h0100);
    else if (x[78:64] == 15'h0000) w = w | ((x[63:0] == 64'h0) ? 16'h4000 : 16'h4400);
    else w = w | 16'h0400;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request; results sampled on the following falling edge
  task automatic run_op(input string req, input logic [1:0] op, input logic [1:0] r,
                        input logic [15:0] st, input logic [79:0] x, input logic emp);
    logic [15:0] es;
    @(negedge clk);
    valid_i = 1'b1; op_i = op; outcome_i = r; status_i = st; operand_i = x; empty_i = emp;
    case (op)
      2'b00: es = m_cmp(st, r);
      2'b01: begin es = st; fl_exp = m_flags(r); end
      2'b10: es = m_exam(st, x, emp);
      default: es = st;
    endcase
    @(negedge clk);
    valid_i = 1'b0;
    chk(req, {16'h0, status_o}, {16'h0, es});
    chk(req, {29'h0, zf_o, pf_o, cf_o}, {29'h0, fl_exp});
    chk("R10 done", {31'h0, done_o}, 32'h1);
  endtask

  task automatic t_reset;
    chk("R1 status", {16'h0, status_o}, 32'h0);
    chk("R1 flags", {29'h0, zf_o, pf_o, cf_o}, 32'h0);
    chk("R1 done", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_sw_cmp;
    for (int r = 0; r < 4; r++) begin
      run_op("R2 cmp ones", 2'b00, r[1:0], 16'hFFFF, '0, 1'b0);
      run_op("R2 cmp zeros", 2'b00, r[1:0], 16'h0000, '0, 1'b0);
      run_op("R3 cmp keep", 2'b00, r[1:0], 16'h3A5A, '0, 1'b0);
    end
  endtask

  task automatic t_fl_cmp;
    for (int r = 0; r < 4; r++)
      run_op("R4 flags", 2'b01, r[1:0], 16'hC3C3, '0, 1'b0);
    run_op("R4 flags set", 2'b01, 2'b11, 16'h1234, '0, 1'b0);
    run_op("R4 flags held by cmp", 2'b00, 2'b00, 16'h0000, '0, 1'b0);
    run_op("R4 flags held by exam", 2'b10, 2'b00, 16'h0000, {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000}, 1'b0);
  endtask

  task automatic t_exam;
    run_op("R6 +inf", 2'b10, 2'b00, 16'hFFFF, {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000}, 1'b0);
    run_op("R6 -inf", 2'b10, 2'b00, 16'h0000, {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000}, 1'b0);
    run_op("R6 nan", 2'b10, 2'b00, 16'h0000, {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000}, 1'b0);
    run_op("R6 nan zero mant", 2'b10, 2'b00, 16'h0000, {1'b1, 15'h7FFF, 64'h0}, 1'b0);
    run_op("R7 zero", 2'b10, 2'b00, 16'h4700, {1'b0, 15'h0000, 64'h0}, 1'b0);
    run_op("R7 -zero", 2'b10, 2'b00, 16'h0000, {1'b1, 15'h0000, 64'h0}, 1'b0);
    run_op("R7 denormal", 2'b10, 2'b00, 16'h0000, {1'b0, 15'h0000, 64'h0000_0000_0000_0001}, 1'b0);
    run_op("R8 normal", 2'b10, 2'b00, 16'hFFFF, {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000}, 1'b0);
    run_op("R8 unnormal", 2'b10, 2'b00, 16'h0000, {1'b1, 15'h0001, 64'h0}, 1'b0);
    run_op("R5 sign clear", 2'b10, 2'b00, 16'h0200, {1'b0, 15'h7FFE, 64'hFFFF_FFFF_FFFF_FFFF}, 1'b0);
    run_op("R9 empty inf", 2'b10, 2'b00, 16'h0000, {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000}, 1'b1);
    run_op("R9 empty neg", 2'b10, 2'b00, 16'hFFFF, {1'b1, 15'h0000, 64'h0}, 1'b1);
  endtask

  task automatic t_back_to_back;
    logic [79:0] x;
    x = {1'b1, 15'h0000, 64'h0000_0000_0000_0010};
    @(negedge clk);
    valid_i = 1'b1; op_i = 2'b01; outcome_i = 2'b00; status_i = 16'h1111; empty_i = 1'b0; operand_i = '0;
    @(negedge clk);
    chk("R10 b2b flags", {29'h0, zf_o, pf_o, cf_o}, 32'h1);
    chk("R10 b2b status1", {16'h0, status_o}, 32'h1111);
    op_i = 2'b10; status_i = 16'h2222; operand_i = x;
    @(negedge clk);
    chk("R10 b2b done", {31'h0, done_o}, 32'h1);
    chk("R10 b2b status2", {16'h0, status_o}, {16'h0, m_exam(16'h2222, x, 1'b0)});
    op_i = 2'b00; outcome_i = 2'b01; status_i = 16'h0500;
    @(negedge clk);
    valid_i = 1'b0;
    chk("R10 b2b done3", {31'h0, done_o}, 32'h1);
    chk("R10 b2b status3", {16'h0, status_o}, 32'h4000);
    chk("R10 b2b flags held", {29'h0, zf_o, pf_o, cf_o}, 32'h1);
    fl_exp = 3'b001;
    @(negedge clk);
    chk("R10 done drops", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_idle;
    logic [15:0] held;
    held = status_o;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_i = i[1:0]; outcome_i = 2'b11; status_i = 16'hA5A5 ^ 16'(i); empty_i = i[0];
      operand_i = {1'b1, 15'h7FFF, 64'h1};
    end
    @(negedge clk);
    chk("R11 status held", {16'h0, status_o}, {16'h0, held});
    chk("R11 flags held", {29'h0, zf_o, pf_o, cf_o}, {29'h0, fl_exp});
    chk("R11 no done", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_pass;
    run_op("R12 pass", 2'b11, 2'b11, 16'hBEEF, {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000}, 1'b1);
    run_op("R12 pass zero", 2'b11, 2'b00, 16'h0000, '0, 1'b0);
  endtask

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    nbad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; op_i = 2'b00; outcome_i = 2'b00;
    status_i = 16'h0; operand_i = '0; empty_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_sw_cmp;
    t_fl_cmp;
    t_exam;
    t_back_to_back;
    t_idle;
    t_pass;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule